// File: doc/BRIEF.md
# Carry-Less Multiplier Unit

This unit multiplies two operand words as polynomials over GF(2). Partial products are combined with XOR instead of addition, so no carries propagate. The full product is twice the operand width. A 2-bit select picks one of three views of it: the lower half, the upper half, or the bit-reversed view. The reversed view equals the product of the two bit-reversed operands, truncated to one word and then reversed again.

The unit is iterative. A one-cycle `start_i` pulse, given while the unit is idle, captures both operands and the select. The unit then handles one multiplier bit per cycle, so a `WIDTH`-bit operation takes `WIDTH` cycles. During that time `busy_o` is high. At the end a single-cycle `done_o` pulse appears with `result_o` already valid. The result stays on `result_o` until the next accepted start. A pipeline can drive the select straight from the low two bits of the instruction's function field.

Top module: `clmul_unit`

## Requirements
- R1: With select 2'b01 (and also 2'b00), the result is bits WIDTH-1:0 of the 2*WIDTH-bit carry-less product opa*opb.
- R2: With select 2'b11, the result is bits 2*WIDTH-1:WIDTH of the carry-less product.
- R3: With select 2'b10, the result is bits 2*WIDTH-2:WIDTH-1 of the carry-less product, which is the same as reversing both operands, keeping the low word of their product and reversing it.
- R4: `done_o` rises exactly WIDTH clock cycles after the edge that accepts `start_i`. It is a single-cycle pulse. `busy_o` is high in every cycle between, and low when `done_o` is high.
- R5: A `start_i` pulse while `busy_o` is high is ignored: it neither restarts the operation nor changes its result or timing.
- R6: Operands and select are captured at the accepted start. Changes on `opa_i`, `opb_i` or `sel_i` during the operation do not affect the result.
- R7: A zero operand gives a zero result for all select values.
- R8: A synchronous active-high `rst` clears `busy_o`, `done_o` and the accumulator, so `result_o` reads zero, even in the middle of an operation.
- R9: While the unit is idle and no start is accepted, `result_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| sel_i | input | 2 | Result view: 01/00 low, 11 high, 10 reversed |
| opa_i | input | WIDTH | Multiplicand |
| opb_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Selected result word, held until next start |

## Verification
A 4-bit instance is swept over every operand pair with every select value. This pattern separates the low, high and reversed views, because each view depends on a different slice of the product. The expected values come from an arithmetic reference. The reference computes the reversed view as a shifted slice of the product rather than by reversal, so it does not copy the datapath's own method.

A 32-bit instance is run with walking ones and all-ones operands, which expose shift-alignment errors at both word edges. It is also run with zero operands and with mixed words. Some of these runs toggle the inputs and pulse start while the unit is busy, to tell apart proper operand capture from a datapath that reads live inputs.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    // Result view, taken from the low two bits of the instruction's function field
    typedef enum logic [1:0] {
        SEL_LOW_ALT = 2'b00,
        SEL_LOW     = 2'b01,
        SEL_REV     = 2'b10,
        SEL_HIGH    = 2'b11
    } clmul_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } clmul_state_e;

    function automatic logic sel_is_rev(input clmul_sel_e s);
        return s == SEL_REV;
    endfunction

endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl
    import clmul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    clmul_state_e  state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign load_o = start_i && (state_q == ST_IDLE);
    assign step_o = (state_q == ST_RUN);
    assign busy_o = (state_q == ST_RUN);
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R4: done only follows a busy cycle and ends it
    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));
    // R5: a running operation is not cut short by any input
    p_run_continues_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q != LAST) |=> (busy_o && !done_o));
    // R8: reset leaves the unit idle
    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o));

endmodule

// File: rtl/clmul_datapath.sv
module clmul_datapath
    import clmul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               step_i,
    input  clmul_sel_e         sel_i,
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    output logic [2*WIDTH-1:0] acc_o,
    output clmul_sel_e         sel_o
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] opa_rev, opb_rev;
    logic [WIDTH-1:0] opa_pick, opb_pick;
    logic [PW-1:0]    mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [PW-1:0]    acc_q;
    clmul_sel_e       sel_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_in_rev
        assign opa_rev[i] = opa_i[WIDTH-1-i];
        assign opb_rev[i] = opb_i[WIDTH-1-i];
    end

    assign opa_pick = sel_is_rev(sel_i) ? opa_rev : opa_i;
    assign opb_pick = sel_is_rev(sel_i) ? opb_rev : opb_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            sel_q    <= SEL_LOW;
        end else if (load_i) begin
            mcand_q  <= {{WIDTH{1'b0}}, opa_pick};
            mplier_q <= opb_pick;
            acc_q    <= '0;
            sel_q    <= sel_i;
        end else if (step_i) begin
            acc_q    <= acc_q ^ (mcand_q & {PW{mplier_q[0]}});
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign acc_o = acc_q;
    assign sel_o = sel_q;

    // R6: captured select does not move during an operation
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> $stable(sel_q));
    // R7: a zero multiplier leaves the accumulator untouched while stepping
    p_zero_mplier_r7: assert property (@(posedge clk) disable iff (rst)
        (step_i && mplier_q == '0) |=> $stable(acc_q));

endmodule

// File: rtl/clmul_select.sv
module clmul_select
    import clmul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] acc_i,
    input  clmul_sel_e         sel_i,
    output logic [WIDTH-1:0]   result_o
);
    logic [WIDTH-1:0] low_rev;

    for (genvar i = 0; i < WIDTH; i++) begin : g_out_rev
        assign low_rev[i] = acc_i[WIDTH-1-i];
    end

    always_comb begin
        case (sel_i)
            SEL_HIGH: result_o = acc_i[2*WIDTH-1:WIDTH];
            SEL_REV:  result_o = low_rev;
            default:  result_o = acc_i[WIDTH-1:0];
        endcase
    end

endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
    import clmul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    logic               load, step;
    logic [2*WIDTH-1:0] acc;
    clmul_sel_e         sel_q;

    clmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    clmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .step_i (step),
        .sel_i  (clmul_sel_e'(sel_i)),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .acc_o  (acc),
        .sel_o  (sel_q)
    );

    clmul_select #(.WIDTH(WIDTH)) u_sel (
        .acc_i    (acc),
        .sel_i    (sel_q),
        .result_o (result_o)
    );

    // R9: idle without an accepted start keeps the result
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(result_o));
    // R8: reset zeroes the visible result
    p_reset_result_r8: assert property (@(posedge clk)
        rst |=> (result_o == '0));

endmodule

// File: tb/tb_clmul_unit.sv
module tb_clmul_unit;
    localparam int W = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          st = 0;
    logic [1:0]    sel = 0;
    logic [W-1:0]  a = 0, b = 0;
    logic          busy, done;
    logic [W-1:0]  res;

    logic          st4 = 0;
    logic [1:0]    sel4 = 0;
    logic [WS-1:0] a4 = 0, b4 = 0;
    logic          busy4, done4;
    logic [WS-1:0] res4;

    int total = 0;
    int bad = 0;

    clmul_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .start_i(st), .sel_i(sel), .opa_i(a), .opb_i(b),
        .busy_o(busy), .done_o(done), .result_o(res));

    clmul_unit #(.WIDTH(WS)) dut4 (
        .clk(clk), .rst(rst), .start_i(st4), .sel_i(sel4), .opa_i(a4), .opb_i(b4),
        .busy_o(busy4), .done_o(done4), .result_o(res4));

    function automatic logic [63:0] cl_prod(input logic [63:0] x, input logic [63:0] y, input int w);
        logic [63:0] p = 64'd0;
        for (int i = 0; i < w; i++)
            if (y[i]) p = p ^ (x << i);
        return p;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                          input logic [1:0] s, input int w);
        logic [63:0] p = cl_prod(x, y, w);
        logic [63:0] m = (64'd1 << w) - 64'd1;
        case (s)
            2'b11:   return (p >> w) & m;
            2'b10:   return (p >> (w - 1)) & m;
            default: return p & m;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'b11:   return "R2";
            2'b10:   return "R3";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_big(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] s,
                           input bit poke, input string req);
        logic [W-1:0] exp;
        logic [W-1:0] held;
        int n;
        exp = W'(model(64'(x), 64'(y), s, W));
        @(negedge clk);
        st = 1; a = x; b = y; sel = s;
        @(negedge clk);
        st = 0; a = ~x; b = ~y; sel = ~s;          // R6: inputs move after capture
        check(busy && !done, "R4", {busy, done}, 2'b10);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) begin
                st = 1; a = x ^ 32'h5a5a5a5a; b = y + 1;   // R5: start while busy
            end else begin
                st = 0;
            end
            if (!done && !busy) break;
        end
        check(n == W, "R4", n, W);
        check(res == exp, poke ? "R5" : req, res, exp);
        held = res;
        @(negedge clk);
        check(!done && !busy, "R4", {busy, done}, 2'b00);
        check(res == held, "R9", res, held);
    endtask

    task automatic run_small(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic [1:0] s);
        logic [WS-1:0] exp;
        int n;
        exp = WS'(model(64'(x), 64'(y), s, WS));
        @(negedge clk);
        st4 = 1; a4 = x; b4 = y; sel4 = s;
        @(negedge clk);
        st4 = 0; a4 = ~x; b4 = ~y;
        n = 0;
        while (!done4 && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == WS && res4 == exp, tag_of(s), {n[7:0], 4'd0, res4}, {8'(WS), 4'd0, exp});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8: reset state
        check(!busy && !done && res == 0, "R8", {busy, done, res}, 0);

        // R1, R2, R3 exhaustive sweep on the 4-bit instance
        for (int s = 0; s < 4; s++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    run_small(WS'(x), WS'(y), 2'(s));

        // walking ones: edge alignment
        for (int i = 0; i < W; i += 7) begin
            run_big(32'd1 << i, 32'h8000_0001, 2'b01, 0, "R1");
            run_big(32'd1 << i, 32'h8000_0001, 2'b11, 0, "R2");
            run_big(32'd1 << i, 32'h8000_0001, 2'b10, 0, "R3");
        end
        run_big(32'hffff_ffff, 32'hffff_ffff, 2'b01, 0, "R1");
        run_big(32'hffff_ffff, 32'hffff_ffff, 2'b11, 0, "R2");
        run_big(32'hffff_ffff, 32'hffff_ffff, 2'b10, 0, "R3");
        run_big(32'h1234_5678, 32'h9abc_def0, 2'b00, 0, "R1");
        run_big(32'hdead_beef, 32'h0bad_f00d, 2'b10, 1, "R3");
        run_big(32'hcafe_0123, 32'h7654_3210, 2'b11, 1, "R2");

        // R7: zero operands for every select
        for (int s = 0; s < 4; s++) begin
            run_big(32'h0, 32'hffff_1234, 2'(s), 0, "R7");
            run_big(32'h89ab_cdef, 32'h0, 2'(s), 0, "R7");
        end

        // R8: reset in the middle of an operation
        @(negedge clk);
        st = 1; a = 32'h7; b = 32'h5; sel = 2'b01;
        @(negedge clk);
        st = 0;
        repeat (5) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(!busy && !done && res == 0, "R8", {busy, done, res}, 0);
        repeat (W + 2) @(negedge clk);
        check(!done && !busy, "R8", {busy, done}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule